// File: doc/BRIEF.md
# Fetch-Directed Instruction Prefetch Engine

A decoupled branch predictor writes predicted fetch-block addresses into a fetch target queue, and the instruction cache reads them later. Prediction can therefore run several blocks ahead of fetch. This engine holds that queue. The oldest entry is the block currently being fetched. The engine walks the entries behind it one per cycle and chooses which of them to prefetch. Each predicted block carries a flag that marks its cache line as evicted from the instruction cache. When the evicted-only mode is on, only flagged blocks are considered.

Before a candidate becomes a request, the engine uses a free instruction-cache tag port to look it up. A tag port counts as free in any cycle the cache does not need it, including cycles with a demand miss outstanding. If the lookup hits, the candidate is dropped and no L2 bandwidth is spent on it. Candidates that survive go into a small queue of line addresses, which removes duplicates. The queue then presents one request at a time to the second-level cache arbiter.

Demand misses always come first on the L2 interface. A parameter sets the minimum spacing between issued prefetches, so the same block serves a bus that accepts a request every cycle and one that accepts a request every fourth cycle.

Top module: `fdp_engine`

## Requirements
- R1: `fetch_valid`/`fetch_addr` present the oldest queued block in push order. `fetch_pop` removes that block. `push_ready` is low when the fetch target queue holds `FTQ_DEPTH` (16) entries, and a push made while it is low is ignored.
- R2: Only entries behind the head are prefetch candidates, so the head block is never probed. The scan moves at most one entry per cycle and never goes past the tail. When pops move the head onto or beyond the scan position, the scan restarts at the entry just behind the new head.
- R3: With `evict_only`=1, a candidate whose evicted flag is 0 is skipped without a probe. With `evict_only`=0, every candidate is eligible.
- R4: `probe_valid` is asserted only in a cycle with `probe_idle`=1. While the port is busy, the scan holds on the current candidate. A `probe_hit` in the same cycle as the probe drops the candidate.
- R5: Addresses are line-aligned to 32-byte lines: bits [4:0] of `fetch_addr`, `probe_addr` and `pf_req_addr` are always zero, and the upper bits come from the pushed address.
- R6: A candidate whose line already sits in the prefetch queue is dropped, so each queued line is requested only once.
- R7: The prefetch queue holds `PF_DEPTH` (8) lines and issues them oldest first. A candidate that arrives while the queue is full is discarded.
- R8: `pf_req_valid` stays low in every cycle that `demand_pending` is high.
- R9: `pf_req_addr` is held until the request is granted. With `L2_GAP`=4, `pf_req_valid` is low for the 3 cycles after a grant.
- R10: `flush` clears the fetch target queue, the scan position and every queued prefetch in the same cycle. In the next cycle `fetch_valid`, `probe_valid` and `pf_req_valid` are all low.
- R11: While `rst_n` is low, `fetch_valid`, `probe_valid` and `pf_req_valid` are 0 and `push_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Misprediction flush |
| evict_only | input | 1 | 1: prefetch only blocks marked evicted |
| push_valid | input | 1 | Predictor pushes a fetch block |
| push_addr | input | ADDR_W | Predicted fetch-block address |
| push_evicted | input | 1 | Block's line was evicted from the instruction cache |
| push_ready | output | 1 | Fetch target queue has room |
| fetch_valid | output | 1 | Head block available to fetch |
| fetch_addr | output | ADDR_W | Line-aligned head block address |
| fetch_pop | input | 1 | Instruction cache consumes the head |
| probe_idle | input | 1 | A tag port is free this cycle |
| probe_valid | output | 1 | Tag lookup request for the candidate |
| probe_addr | output | ADDR_W | Line-aligned candidate address |
| probe_hit | input | 1 | Same-cycle lookup result |
| demand_pending | input | 1 | A demand instruction miss wants the L2 |
| pf_req_valid | output | 1 | Prefetch request to the L2 arbiter |
| pf_req_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_req_grant | input | 1 | Arbiter accepts the request |

## Verification
The bound checker watches, on every cycle, the port relations that hold in any state. These are probing only on a free port, line alignment, demand priority, the held request address, the quiet cycle after a grant, and the cleared outputs after a flush. Other behaviours depend on the history of pushes and pops, so only the bench's scenarios can show them. These are queue order, evicted-flag selection, probe-hit and duplicate dropping, discard when the prefetch queue is full, the scan restart after the head passes it, and the exact length of the request spacing.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
   // Outcome of examining the current scan candidate in one cycle
   typedef enum logic [2:0] {
      CAND_NONE,   // no entry behind the head to examine
      CAND_SKIP,   // not marked evicted while evict-only mode is on
      CAND_WAIT,   // no free tag port, hold position
      CAND_HIT,    // line already resident
      CAND_DUP,    // line already queued for prefetch
      CAND_FULL,   // prefetch queue has no room
      CAND_ENQ     // accepted into the prefetch queue
   } cand_act_e;
endpackage

// File: rtl/fdp_ftq.sv
module fdp_ftq #(
   parameter int LINE_W = 27,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push_valid,
   input  logic [LINE_W-1:0] push_line,
   input  logic              push_evicted,
   output logic              push_ready,
   input  logic              pop,
   output logic              pop_done,
   output logic              head_valid,
   output logic [LINE_W-1:0] head_line,
   output logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  rd_off,
   output logic [LINE_W-1:0] rd_line,
   output logic              rd_evicted
);
   logic [LINE_W-1:0] line_q [DEPTH];
   logic              evict_q [DEPTH];
   logic [PTR_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              do_push;
   logic [PTR_W-1:0]  rd_idx;

   assign push_ready = (cnt_q != CNT_W'(DEPTH));
   assign do_push    = push_valid && push_ready && !flush;
   assign pop_done   = pop && (cnt_q != '0) && !flush;
   assign head_valid = (cnt_q != '0);
   assign head_line  = line_q[head_q];
   assign count      = cnt_q;
   assign rd_idx     = head_q + rd_off[PTR_W-1:0];
   assign rd_line    = line_q[rd_idx];
   assign rd_evicted = evict_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) tail_q <= tail_q + 1'b1;
         if (pop_done) head_q <= head_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(pop_done);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         line_q[tail_q]  <= push_line;
         evict_q[tail_q] <= push_evicted;
      end
   end
endmodule

// File: rtl/fdp_scan.sv
module fdp_scan
   import fdp_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [CNT_W-1:0] count,
   input  logic             pop_done,
   input  logic             cand_evicted,
   input  logic             evict_only,
   input  logic             probe_idle,
   input  logic             probe_hit,
   input  logic             dup_hit,
   input  logic             pq_full,
   output logic [CNT_W-1:0] scan_off,
   output logic             probe_valid,
   output logic             enq
);
   logic [CNT_W-1:0] off_q;
   logic             present, eligible, advance;
   logic [CNT_W:0]   off_nxt;
   cand_act_e        act;

   assign present     = (off_q < count);
   assign eligible    = !evict_only || cand_evicted;
   assign probe_valid = !flush && present && eligible && probe_idle;
   assign scan_off    = off_q;

   always_comb begin
      if (flush || !present)  act = CAND_NONE;
      else if (!eligible)     act = CAND_SKIP;
      else if (!probe_idle)   act = CAND_WAIT;
      else if (probe_hit)     act = CAND_HIT;
      else if (dup_hit)       act = CAND_DUP;
      else if (pq_full)       act = CAND_FULL;
      else                    act = CAND_ENQ;
   end

   assign enq     = (act == CAND_ENQ);
   assign advance = (act != CAND_NONE) && (act != CAND_WAIT);
   assign off_nxt = {1'b0, off_q} + (CNT_W+1)'(advance) - (CNT_W+1)'(pop_done);

   // offset 0 is the head (being fetched); scanning starts just behind it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 off_q <= CNT_W'(1);
      else if (flush)             off_q <= CNT_W'(1);
      else if (off_nxt == '0)     off_q <= CNT_W'(1);
      else                        off_q <= off_nxt[CNT_W-1:0];
   end
endmodule

// File: rtl/fdp_pfq.sv
module fdp_pfq #(
   parameter int LINE_W = 27,
   parameter int DEPTH  = 8,
   parameter int GAP    = 4,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [LINE_W-1:0] cand_line,
   input  logic              enq,
   output logic              dup_hit,
   output logic              full,
   input  logic              demand_pending,
   input  logic              grant,
   output logic              req_valid,
   output logic [LINE_W-1:0] req_line
);
   logic [LINE_W-1:0] q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  wr_idx;
   logic              gap_ok, deq;

   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign req_valid = (cnt_q != '0) && !demand_pending && gap_ok;
   assign req_line  = q[0];
   assign deq       = req_valid && grant && !flush;
   assign wr_idx    = cnt_q - CNT_W'(deq);

   always_comb begin
      dup_hit = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if ((CNT_W'(i) < cnt_q) && (q[i] == cand_line)) dup_hit = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (flush)  cnt_q <= '0;
      else             cnt_q <= cnt_q + CNT_W'(enq) - CNT_W'(deq);
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (deq && (i < DEPTH - 1)) q[i] <= q[(i < DEPTH - 1) ? i + 1 : i];
         if (enq && !flush && (CNT_W'(i) == wr_idx)) q[i] <= cand_line;
      end
   end

   generate
      if (GAP > 1) begin : g_spaced
         localparam int GW = $clog2(GAP);
         logic [GW-1:0] gap_q;
         assign gap_ok = (gap_q == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           gap_q <= '0;
            else if (deq)         gap_q <= GW'(GAP - 1);
            else if (gap_q != '0) gap_q <= gap_q - 1'b1;
         end
      end else begin : g_every_cycle
         assign gap_ok = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/fdp_engine.sv
module fdp_engine #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int FTQ_DEPTH  = 16,
   parameter int PF_DEPTH   = 8,
   parameter int L2_GAP     = 4,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - OFF_W,
   localparam int FCNT_W    = $clog2(FTQ_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              evict_only,
   input  logic              push_valid,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              push_evicted,
   output logic              push_ready,
   output logic              fetch_valid,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_pop,
   input  logic              probe_idle,
   output logic              probe_valid,
   output logic [ADDR_W-1:0] probe_addr,
   input  logic              probe_hit,
   input  logic              demand_pending,
   output logic              pf_req_valid,
   output logic [ADDR_W-1:0] pf_req_addr,
   input  logic              pf_req_grant
);
   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (FTQ_DEPTH < 2 || (1 << $clog2(FTQ_DEPTH)) != FTQ_DEPTH) begin : g_bad_ftq
      $error("FTQ_DEPTH must be a power of two of at least 2");
   end
   if (PF_DEPTH < 1 || L2_GAP < 1 || OFF_W >= ADDR_W) begin : g_bad_cfg
      $error("PF_DEPTH and L2_GAP must be positive; line offset must fit ADDR_W");
   end

   logic [LINE_W-1:0] head_line, cand_line, req_line;
   logic [FCNT_W-1:0] count, scan_off;
   logic              pop_done, cand_evicted, dup_hit, pq_full, enq;

   fdp_ftq #(.LINE_W(LINE_W), .DEPTH(FTQ_DEPTH)) ftq_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push_valid(push_valid), .push_line(push_addr[ADDR_W-1:OFF_W]),
      .push_evicted(push_evicted), .push_ready(push_ready),
      .pop(fetch_pop), .pop_done(pop_done),
      .head_valid(fetch_valid), .head_line(head_line), .count(count),
      .rd_off(scan_off), .rd_line(cand_line), .rd_evicted(cand_evicted)
   );

   fdp_scan #(.CNT_W(FCNT_W)) scan_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .count(count),
      .pop_done(pop_done), .cand_evicted(cand_evicted),
      .evict_only(evict_only), .probe_idle(probe_idle),
      .probe_hit(probe_hit), .dup_hit(dup_hit), .pq_full(pq_full),
      .scan_off(scan_off), .probe_valid(probe_valid), .enq(enq)
   );

   fdp_pfq #(.LINE_W(LINE_W), .DEPTH(PF_DEPTH), .GAP(L2_GAP)) pfq_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .cand_line(cand_line), .enq(enq), .dup_hit(dup_hit), .full(pq_full),
      .demand_pending(demand_pending), .grant(pf_req_grant),
      .req_valid(pf_req_valid), .req_line(req_line)
   );

   assign fetch_addr  = {head_line, {OFF_W{1'b0}}};
   assign probe_addr  = {cand_line, {OFF_W{1'b0}}};
   assign pf_req_addr = {req_line,  {OFF_W{1'b0}}};
endmodule

// File: rtl/fdp_engine_chk.sv
module fdp_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   parameter int L2_GAP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              push_ready,
   input logic              fetch_valid,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              probe_idle,
   input logic              probe_valid,
   input logic [ADDR_W-1:0] probe_addr,
   input logic              demand_pending,
   input logic              pf_req_valid,
   input logic [ADDR_W-1:0] pf_req_addr,
   input logic              pf_req_grant
);
   a_r4_probe_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |-> probe_idle);

   a_r5_probe_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |-> (probe_addr[OFF_W-1:0] == '0));

   a_r5_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      pf_req_valid |-> (pf_req_addr[OFF_W-1:0] == '0));

   a_r5_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (fetch_addr[OFF_W-1:0] == '0));

   a_r8_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
      demand_pending |-> !pf_req_valid);

   a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_req_valid && !pf_req_grant && !flush) |=> $stable(pf_req_addr));

   a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!fetch_valid && !pf_req_valid && !probe_valid));

   a_r1_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
      !push_ready |-> fetch_valid);

   generate
      if (L2_GAP > 1) begin : g_gap_chk
         a_r9_quiet_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
            (pf_req_valid && pf_req_grant) |=> !pf_req_valid);
      end
   endgenerate
endmodule

bind fdp_engine fdp_engine_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .L2_GAP(L2_GAP)) chk_i (
   .clk(clk), .rst_n(rst_n), .flush(flush), .push_ready(push_ready),
   .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
   .probe_idle(probe_idle), .probe_valid(probe_valid), .probe_addr(probe_addr),
   .demand_pending(demand_pending), .pf_req_valid(pf_req_valid),
   .pf_req_addr(pf_req_addr), .pf_req_grant(pf_req_grant)
);

// File: tb/fdp_engine_tb_top.sv
`timescale 1ns/1ps
module fdp_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0, evict_only = 1'b0;
   logic        push_valid = 1'b0, push_evicted = 1'b0;
   logic [31:0] push_addr = '0;
   logic        push_ready, fetch_valid, fetch_pop = 1'b0;
   logic [31:0] fetch_addr, probe_addr, pf_req_addr;
   logic        probe_idle = 1'b1, probe_valid, probe_hit;
   logic        demand_pending = 1'b0, pf_req_valid, pf_req_grant = 1'b0;
   logic        res_en = 1'b0;
   logic [31:0] res_line = '0;
   int          n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   // tag model: one resident line, same-cycle lookup result
   assign probe_hit = probe_valid && res_en && (probe_addr[31:5] == res_line[31:5]);

   fdp_engine dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .evict_only(evict_only),
      .push_valid(push_valid), .push_addr(push_addr), .push_evicted(push_evicted),
      .push_ready(push_ready), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .fetch_pop(fetch_pop), .probe_idle(probe_idle), .probe_valid(probe_valid),
      .probe_addr(probe_addr), .probe_hit(probe_hit), .demand_pending(demand_pending),
      .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr), .pf_req_grant(pf_req_grant)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic        ev;
      logic        mode;
      logic        res;
      logic        issue;
   } vec_t;

   localparam vec_t VECS [0:7] = '{
      '{32'h2000_0040, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 flagged, mode on
      '{32'h2000_0080, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 unflagged skipped
      '{32'h2000_00C0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 mode off
      '{32'h2000_0100, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 probe hit drops
      '{32'h2000_015C, 1'b1, 1'b0, 1'b0, 1'b1},  // R5 unaligned input
      '{32'h2000_0184, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 hit on same line
      '{32'h3000_0000, 1'b0, 1'b0, 1'b0, 1'b1},
      '{32'h3000_0020, 1'b1, 1'b1, 1'b0, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(input logic [31:0] a, input logic ev);
      push_valid = 1'b1; push_addr = a; push_evicted = ev;
      tick();
      push_valid = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      tick();
      flush = 1'b0;
   endtask

   task automatic grant_one();
      pf_req_grant = 1'b1;
      tick();
      pf_req_grant = 1'b0;
      #0.5;
   endtask

   task automatic pop_one();
      fetch_pop = 1'b1;
      tick();
      fetch_pop = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!fetch_valid && !pf_req_valid && !probe_valid, "R11 outputs idle", {29'b0, fetch_valid, pf_req_valid, probe_valid}, 0);
      chk(push_ready, "R11 push_ready", {31'b0, push_ready}, 1);
      rst_n = 1'b1;
      tick();

      // table of candidate scenarios
      for (int v = 0; v < 8; v++) begin
         do_flush();
         evict_only = VECS[v].mode;
         res_en     = VECS[v].res;
         res_line   = VECS[v].addr;
         push(32'h1000_0000, 1'b0);
         push(VECS[v].addr, VECS[v].ev);
         tick(); tick();
         chk(pf_req_valid == VECS[v].issue, "R3/R4 issue decision", {31'b0, pf_req_valid}, {31'b0, VECS[v].issue});
         if (VECS[v].issue) begin
            chk(pf_req_addr == {VECS[v].addr[31:5], 5'b0}, "R5 aligned request", pf_req_addr, {VECS[v].addr[31:5], 5'b0});
            grant_one();
         end
         repeat (4) tick();
         chk(!pf_req_valid, "R2 head block not prefetched", {31'b0, pf_req_valid}, 0);
         res_en = 1'b0;
      end

      // R1 order, full and ignored push
      do_flush();
      evict_only = 1'b1;
      for (int i = 0; i < 16; i++) push(32'h4000_0000 + 32'(i * 32), 1'b0);
      chk(!push_ready, "R1 full at depth", {31'b0, push_ready}, 0);
      push(32'h4FFF_0000, 1'b0);
      for (int i = 0; i < 16; i++) begin
         chk(fetch_valid && fetch_addr == 32'h4000_0000 + 32'(i * 32), "R1 fetch order", fetch_addr, 32'h4000_0000 + 32'(i * 32));
         pop_one();
      end
      chk(!fetch_valid, "R1 push while full ignored", {31'b0, fetch_valid}, 0);

      // R6 duplicate lines
      do_flush();
      evict_only = 1'b0;
      push(32'h1000_0000, 1'b0);
      push(32'h5000_0000, 1'b0);
      push(32'h5000_0004, 1'b0);
      push(32'h5000_0018, 1'b0);
      tick(); tick();
      chk(pf_req_valid && pf_req_addr == 32'h5000_0000, "R6 first copy", pf_req_addr, 32'h5000_0000);
      grant_one();
      repeat (4) tick();
      chk(!pf_req_valid, "R6 duplicates dropped", {31'b0, pf_req_valid}, 0);

      // R7 capacity and order, R9 spacing
      do_flush();
      push(32'h1000_0000, 1'b0);
      for (int i = 0; i < 9; i++) push(32'h6000_0000 + 32'(i * 32), 1'b0);
      tick(); tick();
      for (int i = 0; i < 8; i++) begin
         chk(pf_req_valid && pf_req_addr == 32'h6000_0000 + 32'(i * 32), "R7 oldest first", pf_req_addr, 32'h6000_0000 + 32'(i * 32));
         grant_one();
         if (i == 0) begin
            chk(!pf_req_valid, "R9 gap cycle 1", {31'b0, pf_req_valid}, 0);
            tick();
            chk(!pf_req_valid, "R9 gap cycle 2", {31'b0, pf_req_valid}, 0);
            tick();
            chk(!pf_req_valid, "R9 gap cycle 3", {31'b0, pf_req_valid}, 0);
            tick();
            chk(pf_req_valid, "R9 ready after 4 cycles", {31'b0, pf_req_valid}, 1);
         end else begin
            repeat (3) tick();
         end
      end
      tick();
      chk(!pf_req_valid, "R7 ninth candidate discarded", {31'b0, pf_req_valid}, 0);

      // R8 demand priority
      do_flush();
      push(32'h1000_0000, 1'b0);
      push(32'h7000_0040, 1'b0);
      tick(); tick();
      demand_pending = 1'b1; #0.5;
      chk(!pf_req_valid, "R8 demand blocks prefetch", {31'b0, pf_req_valid}, 0);
      demand_pending = 1'b0; #0.5;
      chk(pf_req_valid && pf_req_addr == 32'h7000_0040, "R8 prefetch after demand", pf_req_addr, 32'h7000_0040);
      grant_one();
      repeat (4) tick();

      // R4 busy tag port holds the scan
      do_flush();
      probe_idle = 1'b0;
      push(32'h1000_0000, 1'b0);
      push(32'h7100_0000, 1'b0);
      tick(); tick();
      chk(!probe_valid && !pf_req_valid, "R4 no probe while busy", {30'b0, probe_valid, pf_req_valid}, 0);
      probe_idle = 1'b1; #0.5;
      chk(probe_valid && probe_addr == 32'h7100_0000, "R4 probe when idle", probe_addr, 32'h7100_0000);
      tick(); tick();
      chk(pf_req_valid && pf_req_addr == 32'h7100_0000, "R4 issued after probe", pf_req_addr, 32'h7100_0000);
      grant_one();
      repeat (4) tick();

      // R2 head consumed past the scan position
      do_flush();
      probe_idle = 1'b0;
      push(32'h1000_0000, 1'b0);
      push(32'h7200_0000, 1'b0);
      push(32'h7200_0020, 1'b0);
      pop_one();
      pop_one();
      probe_idle = 1'b1;
      repeat (3) tick();
      chk(!pf_req_valid && !probe_valid, "R2 scan restarts behind head", {30'b0, probe_valid, pf_req_valid}, 0);
      push(32'h7200_0040, 1'b0);
      tick(); tick();
      chk(pf_req_valid && pf_req_addr == 32'h7200_0040, "R2 next entry scanned", pf_req_addr, 32'h7200_0040);
      grant_one();
      repeat (4) tick();

      // R10 flush
      push(32'h1000_0000, 1'b0);
      push(32'h7300_0000, 1'b0);
      tick(); tick();
      push(32'h7300_0020, 1'b0);
      do_flush();
      chk(!fetch_valid && !pf_req_valid && !probe_valid, "R10 flush clears", {29'b0, fetch_valid, pf_req_valid, probe_valid}, 0);
      repeat (4) tick();
      chk(!fetch_valid && !pf_req_valid, "R10 stays clear", {30'b0, fetch_valid, pf_req_valid}, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule